// File: doc/BRIEF.md
# Far-End Receiver Detection Sequencer

This block sits on the link-layer side of a PIPE-style PHY interface and runs the far-end receiver presence check for one lane. When asked to start, it forces the transmitter into electrical idle. It holds that state for a minimum number of clock cycles so that the output buffer has time to go tri-state. Only then does it raise the detect request toward the PHY.

Once the request is up, the block waits for the PHY's completion pulse and reads the three-bit status in that same cycle. It then drops the request and raises a one-cycle done pulse. The result is one of four outcomes: receiver found, receiver absent, protocol error (any status code other than the two defined ones), or timeout (the PHY never answered). After the report, the sequencer returns to idle and hands the transmitter back by releasing electrical idle.

The lead time is a parameter with a floor of 10 cycles. A smaller value stops elaboration.

Top module: `rxdet_seq`

## Requirements
- R1: While reset (synchronous, active-high) is applied and in the cycle after it, force_idle_o is 1 and detect_req_o, busy_o, done_o, found_o, timeout_o and proto_err_o are all 0.
- R2: A start_i sampled high while the block is not busy sets busy_o and force_idle_o in the next cycle. detect_req_o rises exactly LEAD_CYCLES cycles after busy_o rises.
- R3: force_idle_o is 1 in every cycle in which busy_o or detect_req_o is 1.
- R4: When phy_done_i is sampled high while detect_req_o is high and phy_status_i is 3'b011, the report sets found_o=1, proto_err_o=0 and timeout_o=0.
- R5: When phy_status_i is 3'b000 at completion, the report sets found_o=0, proto_err_o=0 and timeout_o=0.
- R6: Any other phy_status_i value at completion sets proto_err_o=1 and found_o=0.
- R7: detect_req_o falls in the cycle after phy_done_i is sampled. done_o is high for exactly that one cycle, and busy_o falls in the following cycle.
- R8: If phy_done_i does not arrive within TIMEOUT_CYCLES cycles of detect_req_o rising, detect_req_o drops and the report sets timeout_o=1 with found_o=0.
- R9: start_i is ignored while busy_o is 1. phy_done_i is ignored outside the detect request window.
- R10: After a sequence completes, force_idle_o is 0 while idle. The result flags hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run one detection sequence |
| phy_done_i | input | 1 | PHY completion status pulse |
| phy_status_i | input | 3 | PHY receive status, valid with phy_done_i |
| force_idle_o | output | 1 | Force transmitter electrical idle |
| detect_req_o | output | 1 | Detect/loopback request to the PHY |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Receiver detected |
| timeout_o | output | 1 | PHY did not respond in time |
| proto_err_o | output | 1 | Undefined status code at completion |

## Verification
The assertions check three things on every cycle. The first is that the detect request is never raised before electrical idle has been held for the full lead time. The second is that the request only appears under electrical idle and never outlasts the timeout window. The third is that the done pulse is one cycle wide, the request drops right after completion, and the result flags are mutually exclusive. Only the bench scenarios can show that each status code maps to the right flag, that starts during a sequence are discarded, and that results persist until the next start. They can also show the exact cycle counts of the lead and timeout paths; the bench checks these against a behavioural model on every clock.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_DETECT = 2'd2,
    ST_REPORT = 2'd3
  } rxdet_state_e;

  localparam logic [2:0] STAT_PRESENT = 3'b011;
  localparam logic [2:0] STAT_ABSENT  = 3'b000;
endpackage

// File: rtl/rxdet_count.sv
module rxdet_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= q + 1'b1;
  end
endmodule

// File: rtl/rxdet_decode.sv
module rxdet_decode
  import rxdet_pkg::*;
(
  input  logic [2:0] status,
  output logic       present,
  output logic       bad_code
);
  always_comb begin
    present  = (status == STAT_PRESENT);
    bad_code = !((status == STAT_PRESENT) || (status == STAT_ABSENT));
  end
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
  import rxdet_pkg::*;
#(
  parameter int LEAD_CYCLES    = 10,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       phy_done_i,
  input  logic [2:0] phy_status_i,
  output logic       force_idle_o,
  output logic       detect_req_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       found_o,
  output logic       timeout_o,
  output logic       proto_err_o
);
  localparam int SPAN  = (LEAD_CYCLES > TIMEOUT_CYCLES) ? LEAD_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam int LRW   = $clog2(LEAD_CYCLES + 1);

  generate
    if (LEAD_CYCLES < 10) begin : g_bad_lead
      $error("rxdet_seq: LEAD_CYCLES must be at least 10");
    end
  endgenerate

  rxdet_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_clr, cnt_en, lead_end, wait_end;
  logic             st_present, st_bad;

  assign lead_end = (cnt_q == CNT_W'(LEAD_CYCLES - 1));
  assign wait_end = (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));
  assign cnt_clr  = (state_q == ST_IDLE) || (state_q == ST_LEAD && lead_end);
  assign cnt_en   = (state_q == ST_LEAD) || (state_q == ST_DETECT);

  rxdet_count #(.W(CNT_W)) u_count (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (cnt_en),
    .q   (cnt_q)
  );

  rxdet_decode u_decode (
    .status   (phy_status_i),
    .present  (st_present),
    .bad_code (st_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      force_idle_o <= 1'b1;
      detect_req_o <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      found_o      <= 1'b0;
      timeout_o    <= 1'b0;
      proto_err_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q      <= ST_LEAD;
            force_idle_o <= 1'b1;
            busy_o       <= 1'b1;
            found_o      <= 1'b0;
            timeout_o    <= 1'b0;
            proto_err_o  <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (lead_end) begin
            state_q      <= ST_DETECT;
            detect_req_o <= 1'b1;
          end
        end
        ST_DETECT: begin
          if (phy_done_i) begin
            state_q      <= ST_REPORT;
            detect_req_o <= 1'b0;
            done_o       <= 1'b1;
            found_o      <= st_present;
            proto_err_o  <= st_bad;
          end else if (wait_end) begin
            state_q      <= ST_REPORT;
            detect_req_o <= 1'b0;
            done_o       <= 1'b1;
            timeout_o    <= 1'b1;
          end
        end
        default: begin
          state_q      <= ST_IDLE;
          done_o       <= 1'b0;
          busy_o       <= 1'b0;
          force_idle_o <= 1'b0;
        end
      endcase
    end
  end

  // Checker state: run lengths of electrical idle and of the detect request.
  logic [LRW-1:0]   idle_run;
  logic [CNT_W:0]   req_run;

  always_ff @(posedge clk) begin
    if (rst || !force_idle_o)            idle_run <= '0;
    else if (idle_run < LRW'(LEAD_CYCLES)) idle_run <= idle_run + 1'b1;
    if (rst || !detect_req_o) req_run <= '0;
    else                      req_run <= req_run + 1'b1;
  end

  // R2: request only after the full lead time under electrical idle
  p_lead_time_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_req_o) |-> (idle_run == LRW'(LEAD_CYCLES)));

  // R3: request only while the transmitter is held idle
  p_idle_cover_r3: assert property (@(posedge clk) disable iff (rst)
    (detect_req_o || busy_o) |-> force_idle_o);

  // R7: request drops after completion, done is a single-cycle pulse
  p_req_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (detect_req_o && phy_done_i) |=> (!detect_req_o && done_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: request never outlives the timeout window
  p_timeout_bound_r8: assert property (@(posedge clk) disable iff (rst)
    req_run <= (CNT_W + 1)'(TIMEOUT_CYCLES));

  // R6: outcome flags are exclusive at report time
  p_excl_result_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones({found_o, timeout_o, proto_err_o}) <= 1));

  // R9: an idle block accepts start
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);
endmodule

// File: tb/rxdet_seq_test.sv
module rxdet_seq_test;
  localparam int LEAD = 10;
  localparam int TOUT = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       phy_done_i = 1'b0;
  logic [2:0] phy_status_i = 3'b111;
  logic       force_idle_o, detect_req_o, busy_o, done_o, found_o, timeout_o, proto_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rxdet_seq #(.LEAD_CYCLES(LEAD), .TIMEOUT_CYCLES(TOUT)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .phy_done_i(phy_done_i),
    .phy_status_i(phy_status_i), .force_idle_o(force_idle_o),
    .detect_req_o(detect_req_o), .busy_o(busy_o), .done_o(done_o),
    .found_o(found_o), .timeout_o(timeout_o), .proto_err_o(proto_err_o)
  );

  // Behavioural reference: phase 0 idle, 1 lead, 2 waiting, 3 report
  int   m_phase = 0;
  int   m_ticks = 0;
  logic e_idle = 1'b1, e_req = 1'b0, e_busy = 1'b0, e_done = 1'b0;
  logic e_found = 1'b0, e_to = 1'b0, e_err = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; e_idle = 1; e_req = 0; e_busy = 0; e_done = 0;
      e_found = 0; e_to = 0; e_err = 0;
    end else if (m_phase == 0) begin
      if (start_i) begin
        m_phase = 1; m_ticks = 1; e_idle = 1; e_busy = 1;
        e_found = 0; e_to = 0; e_err = 0;
      end
    end else if (m_phase == 1) begin
      if (m_ticks == LEAD) begin m_phase = 2; m_ticks = 1; e_req = 1; end
      else m_ticks++;
    end else if (m_phase == 2) begin
      if (phy_done_i) begin
        m_phase = 3; e_req = 0; e_done = 1;
        e_found = (phy_status_i == 3'b011);
        e_err   = (phy_status_i != 3'b011) && (phy_status_i != 3'b000);
      end else if (m_ticks == TOUT) begin
        m_phase = 3; e_req = 0; e_done = 1; e_to = 1;
      end else m_ticks++;
    end else begin
      m_phase = 0; e_done = 0; e_busy = 0; e_idle = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("R3", "force_idle_o", force_idle_o, e_idle);
    chk("R2", "detect_req_o", detect_req_o, e_req);
    chk("R9", "busy_o",       busy_o,       e_busy);
    chk("R7", "done_o",       done_o,       e_done);
    chk("R4", "found_o",      found_o,      e_found);
    chk("R8", "timeout_o",    timeout_o,    e_to);
    chk("R6", "proto_err_o",  proto_err_o,  e_err);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One sequence; poke raises start again mid-sequence (R9)
  task automatic run_seq(int dly, logic [2:0] st, bit reply, bit poke);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = poke;
    @(negedge clk) start_i = 1'b0;
    while (!detect_req_o) @(negedge clk);
    if (reply) begin
      repeat (dly) @(negedge clk);
      if (poke) start_i = 1'b1;
      phy_done_i = 1'b1; phy_status_i = st;
      @(negedge clk) phy_done_i = 1'b0; phy_status_i = 3'b111; start_i = 1'b0;
    end else begin
      while (detect_req_o) @(negedge clk);
    end
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset force_idle_o", force_idle_o, 1'b1);
    chk("R1", "reset detect_req_o", detect_req_o, 1'b0);
    chk("R1", "reset busy_o", busy_o, 1'b0);
    rst = 1'b0;
    // R9: stray completion while idle must be ignored
    @(negedge clk) phy_done_i = 1'b1; phy_status_i = 3'b011;
    @(negedge clk) phy_done_i = 1'b0; phy_status_i = 3'b111;
    chk("R9", "stray done ignored", found_o, 1'b0);
    chk("R1", "after reset busy_o", busy_o, 1'b0);

    run_seq(3, 3'b011, 1'b1, 1'b1);   // R4 present, starts while busy
    chk("R4", "present result", found_o, 1'b1);
    repeat (2) @(negedge clk);
    chk("R10", "idle released", force_idle_o, 1'b0);
    chk("R10", "result held", found_o, 1'b1);

    run_seq(0, 3'b000, 1'b1, 1'b0);   // R5 absent, immediate reply
    chk("R5", "absent found_o", found_o, 1'b0);
    chk("R5", "absent proto_err_o", proto_err_o, 1'b0);
    chk("R5", "absent timeout_o", timeout_o, 1'b0);

    run_seq(7, 3'b101, 1'b1, 1'b0);   // R6 undefined code
    chk("R6", "bad code flag", proto_err_o, 1'b1);
    run_seq(1, 3'b010, 1'b1, 1'b0);
    chk("R6", "bad code 010 flag", proto_err_o, 1'b1);

    run_seq(0, 3'b000, 1'b0, 1'b1);   // R8 no reply
    chk("R8", "timeout flag", timeout_o, 1'b1);
    chk("R8", "timeout no found", found_o, 1'b0);

    run_seq(20, 3'b011, 1'b1, 1'b0);  // R10 start clears old timeout
    chk("R10", "timeout cleared", timeout_o, 1'b0);
    chk("R4", "late reply present", found_o, 1'b1);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule